// File: doc/BRIEF.md
# Laser Trigger Output Sequencer

This block paces a pulsed light source during laser-mode acquisition. A host first writes an 8-bit delay code, which selects 0 to 255 ns in 1 ns steps on an external digital delay element, and an event count. It then writes a start command. The sequencer shifts the delay code serially into the delay element and closes the transfer with a load strobe. Only after that does it emit trigger pulses at a fixed repetition rate, by default one every 40000 clocks, which is 1 kHz from a 40 MHz clock. It stops when the requested number of events has been issued.

Each trigger pulse is followed by a one-cycle readout trigger toward the front-end chips after a fixed pipeline latency, by default 128 clocks. A busy flag covers the whole run, up to and including the last readout trigger. A stop command ends a run early: no new triggers are issued, and a readout trigger that is already pending is still delivered. Stepping the delay code from run to run moves the light pulse across the front-end shaping window.

Top module: `laser_trig_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, trig_out, fe_trig, busy, dly_sdata, dly_sclk and dly_load are all low.
- R2: Host writes decode wr_addr as follows. Address 0 sets the delay code from wr_data[7:0]. Address 1 sets the event count from wr_data[15:0]. Address 2 is the command word: bit 0 starts a run and bit 1 stops it.
- R3: An accepted start shifts the delay code out on dly_sdata, most significant bit first. There are exactly 8 rising edges of dly_sclk, one every SCLK_DIV clocks, with data stable while dly_sclk is high. A one-cycle dly_load pulse follows, with dly_sclk low, in the 8·SCLK_DIV-th cycle after busy rises.
- R4: No trigger precedes the load strobe. The first trig_out rise of a run comes exactly 2 cycles after the dly_load cycle.
- R5: Within a run, successive trig_out rises are exactly PERIOD cycles apart.
- R6: Each trig_out pulse is high for exactly PULSE_W cycles.
- R7: fe_trig is a one-cycle pulse that rises exactly LATENCY cycles after each trig_out rise. There is one such pulse per trigger.
- R8: A run issues as many triggers as the event count. A written count above MAX_EVT is stored as MAX_EVT.
- R9: A start is ignored while the event count is zero, and it is ignored while busy is high.
- R10: busy rises in the cycle after an accepted start write. At the end of a completed run it falls in the cycle after the last fe_trig.
- R11: Delay code and event count writes made during a run cause no activity on the serial lines and do not alter that run. They take effect at the next start.
- R12: A stop ends a run with no further trig_out rises. A readout trigger already pending is delivered before busy falls. A stop given during the serial load waits for the strobe. A command word with both bits set counts as a stop only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | DATA_W | Host write data |
| dly_sdata | output | 1 | Serial data to the delay element |
| dly_sclk | output | 1 | Shift clock to the delay element |
| dly_load | output | 1 | Load strobe to the delay element |
| trig_out | output | 1 | Trigger pulse to the light source driver |
| fe_trig | output | 1 | Readout trigger to the front-end chips |
| busy | output | 1 | Run in progress |

## Verification
A corrupted shift register or bit counter shows up at the delay element's strobe. The captured code differs from the one written, or the number of shift edges is not 8, and both are known by the end of the first load. A wrong period, pulse or latency counter moves a trig_out or fe_trig edge by whole cycles, and that is visible at the next trigger. A wrong remaining-event count or state appears as a trigger total that differs from the request once busy falls, or as busy falling at the wrong time relative to the last readout trigger. The bench sweeps all 256 delay codes and every event count of a small configuration.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } lts_state_e;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_STROBE = 2'd2
    } lts_ld_e;

    localparam logic [1:0] LTS_A_DELAY = 2'd0;
    localparam logic [1:0] LTS_A_COUNT = 2'd1;
    localparam logic [1:0] LTS_A_CMD   = 2'd2;

endpackage

// File: rtl/lts_serial_loader.sv
module lts_serial_loader
    import lts_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int SCLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] value,
    output logic             sdata,
    output logic             sclk,
    output logic             load,
    output logic             ld_busy
);
    localparam int DIV_W = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int BIT_W = (DLY_W > 2) ? $clog2(DLY_W) : 1;

    typedef struct packed {
        lts_ld_e          st;
        logic [DLY_W-1:0] sh;
        logic [DIV_W-1:0] ph;
        logic [BIT_W-1:0] nb;
    } ld_regs_t;

    ld_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            LD_IDLE: begin
                if (start) begin
                    r_d.st = LD_SHIFT;
                    r_d.sh = value;
                    r_d.ph = '0;
                    r_d.nb = '0;
                end
            end
            LD_SHIFT: begin
                if (r_q.ph == DIV_W'(SCLK_DIV - 1)) begin
                    r_d.ph = '0;
                    r_d.sh = {r_q.sh[DLY_W-2:0], 1'b0};
                    if (r_q.nb == BIT_W'(DLY_W - 1)) begin
                        r_d.st = LD_STROBE;
                    end else begin
                        r_d.nb = r_q.nb + BIT_W'(1);
                    end
                end else begin
                    r_d.ph = r_q.ph + DIV_W'(1);
                end
            end
            default: r_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: LD_IDLE, sh: '0, ph: '0, nb: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sdata   = (r_q.st == LD_SHIFT) && r_q.sh[DLY_W-1];
    assign sclk    = (r_q.st == LD_SHIFT) && (r_q.ph >= DIV_W'(SCLK_DIV / 2));
    assign load    = (r_q.st == LD_STROBE);
    assign ld_busy = (r_q.st != LD_IDLE);

    // R3: the strobe lasts one cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R3: the strobe follows the high phase of the last shift clock
    a_r3_strobe_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(sclk));

    // R3: data does not move while the shift clock stays high
    a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

endmodule

// File: rtl/lts_pulse_timer.sv
module lts_pulse_timer #(
    parameter int PERIOD  = 40000,
    parameter int PULSE_W = 4,
    parameter int LATENCY = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fire,
    output logic trig_out,
    output logic fe_trig,
    output logic fe_pend
);
    localparam int PER_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int PW_W  = $clog2(PULSE_W + 1);
    localparam int LAT_W = $clog2(LATENCY) + 1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PW_W-1:0]  pw;
        logic [LAT_W-1:0] lat;
        logic             pend;
        logic             fe;
    } tm_regs_t;

    tm_regs_t r_q, r_d;

    assign fire = en && (r_q.cnt == '0);

    always_comb begin
        r_d    = r_q;
        r_d.fe = 1'b0;
        if (!en) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == PER_W'(PERIOD - 1)) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + PER_W'(1);
        end

        if (fire) begin
            r_d.pw = PW_W'(PULSE_W);
        end else if (r_q.pw != '0) begin
            r_d.pw = r_q.pw - PW_W'(1);
        end

        if (fire) begin
            r_d.pend = 1'b1;
            r_d.lat  = LAT_W'(LATENCY - 1);
        end else if (r_q.pend) begin
            if (r_q.lat == '0) begin
                r_d.pend = 1'b0;
                r_d.fe   = 1'b1;
            end else begin
                r_d.lat = r_q.lat - LAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trig_out = (r_q.pw != '0);
    assign fe_trig  = r_q.fe;
    assign fe_pend  = r_q.pend;

    // R7: one readout trigger cycle per event
    a_r7_fe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fe_trig |=> !fe_trig);

    // R5: a new trigger never starts on top of the previous pulse
    a_r5_fire_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !trig_out);

    generate
        if (PULSE_W > 1) begin : g_width_chk
            // R6: a pulse that has just risen is still high next cycle
            a_r6_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(trig_out) |=> trig_out);
        end
    endgenerate

endmodule

// File: rtl/laser_trig_seq.sv
module laser_trig_seq
    import lts_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int DATA_W   = 16,
    parameter int MAX_EVT  = 64776,
    parameter int PERIOD   = 40000,
    parameter int PULSE_W  = 4,
    parameter int LATENCY  = 128,
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              dly_sdata,
    output logic              dly_sclk,
    output logic              dly_load,
    output logic              trig_out,
    output logic              fe_trig,
    output logic              busy
);
    typedef struct packed {
        lts_state_e        st;
        logic [DLY_W-1:0]  dly;
        logic [DATA_W-1:0] evt;
        logic [DATA_W-1:0] rem;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic is_cmd, go, halt, ld_start;
    logic ld_done, ld_busy;
    logic run_en, fire, fe_pend;

    assign is_cmd   = wr_en && (wr_addr == LTS_A_CMD);
    assign halt     = is_cmd && wr_data[1];
    assign go       = is_cmd && wr_data[0] && !wr_data[1];
    assign ld_start = (r_q.st == ST_IDLE) && go && (r_q.evt != '0);
    assign run_en   = (r_q.st == ST_RUN);

    lts_serial_loader #(
        .DLY_W   (DLY_W),
        .SCLK_DIV(SCLK_DIV)
    ) u_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ld_start),
        .value  (r_q.dly),
        .sdata  (dly_sdata),
        .sclk   (dly_sclk),
        .load   (ld_done),
        .ld_busy(ld_busy)
    );

    lts_pulse_timer #(
        .PERIOD (PERIOD),
        .PULSE_W(PULSE_W),
        .LATENCY(LATENCY)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .fire    (fire),
        .trig_out(trig_out),
        .fe_trig (fe_trig),
        .fe_pend (fe_pend)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && (wr_addr == LTS_A_DELAY)) begin
            r_d.dly = wr_data[DLY_W-1:0];
        end
        if (wr_en && (wr_addr == LTS_A_COUNT)) begin
            r_d.evt = (wr_data > DATA_W'(MAX_EVT)) ? DATA_W'(MAX_EVT) : wr_data;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (ld_start) begin
                    r_d.st  = ST_LOAD;
                    r_d.rem = r_q.evt;
                end
            end
            ST_LOAD: begin
                if (halt) begin
                    r_d.st = ST_DRAIN;
                end else if (ld_done) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fire) begin
                    r_d.rem = r_q.rem - DATA_W'(1);
                    if (r_q.rem == DATA_W'(1)) begin
                        r_d.st = ST_DRAIN;
                    end
                end
                if (halt) begin
                    r_d.st = ST_DRAIN;
                end
            end
            default: begin
                if (!fe_pend && !ld_busy) begin
                    r_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, dly: '0, evt: '0, rem: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dly_load = ld_done;
    assign busy     = (r_q.st != ST_IDLE);

    // R8: the run state always has events left to issue
    a_r8_run_has_events: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (r_q.rem != '0));

    // R10: once not busy, no readout trigger is outstanding
    a_r10_idle_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fe_pend);

    // R4: the serial transfer and triggering never overlap
    a_r4_no_fire_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
        ld_busy |-> !fire);

    // R9: an idle sequencer with no events never enters the load
    a_r9_zero_count_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && (r_q.evt == '0)) |=> !ld_busy);

endmodule

// File: tb/laser_trig_seq_test.sv
module laser_trig_seq_test;

    localparam int T_PERIOD  = 20;
    localparam int T_PULSE   = 4;
    localparam int T_LAT     = 7;
    localparam int T_DIV     = 4;
    localparam int T_MAXEVT  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        dly_sdata, dly_sclk, dly_load, trig_out, fe_trig, busy;

    always #2.5 clk = ~clk;

    laser_trig_seq #(
        .DLY_W(8), .DATA_W(16), .MAX_EVT(T_MAXEVT), .PERIOD(T_PERIOD),
        .PULSE_W(T_PULSE), .LATENCY(T_LAT), .SCLK_DIV(T_DIV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dly_sdata(dly_sdata), .dly_sclk(dly_sclk),
        .dly_load(dly_load), .trig_out(trig_out), .fe_trig(fe_trig), .busy(busy)
    );

    int checks = 0, fails = 0;
    int m_checks = 0, m_fails = 0;
    bit wd = 1'b0;
    bit stop_run = 1'b0;
    logic [7:0] exp_dly = 8'd0;

    // monitor state
    int cyc = 0, rise_cyc = 0, last_fe = 0, load_cyc = 0, busy_rise = 0, wlen = 0;
    int trig_n = 0, fe_n = 0, sclk_n = 0, load_n = 0, bits = 0;
    logic [7:0] cap = 8'd0;
    bit first_pend = 1'b0;
    logic p_trig = 1'b0, p_sclk = 1'b0, p_busy = 1'b0;

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        m_checks++;
        if (!ok) begin
            m_fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !p_busy) busy_rise = cyc;
            if (dly_sclk && !p_sclk) begin
                cap = {cap[6:0], dly_sdata};
                bits++;
                sclk_n++;
            end
            if (dly_load) begin
                // R3: code, edge count and strobe timing
                mchk(bits == 8, "R3 shift edges", bits, 8);
                mchk(cap == exp_dly, "R3 shifted code", cap, exp_dly);
                mchk(cyc - busy_rise == 8 * T_DIV, "R3 strobe timing", cyc - busy_rise, 8 * T_DIV);
                mchk(!dly_sclk, "R3 clock low at strobe", dly_sclk, 0);
                bits = 0;
                load_cyc = cyc;
                first_pend = 1'b1;
                load_n++;
            end
            if (trig_out && !p_trig) begin
                if (first_pend) mchk(cyc - load_cyc == 2, "R4 first trigger", cyc - load_cyc, 2);
                else mchk(cyc - rise_cyc == T_PERIOD, "R5 period", cyc - rise_cyc, T_PERIOD);
                first_pend = 1'b0;
                rise_cyc = cyc;
                trig_n++;
                wlen = 1;
            end else if (trig_out) begin
                wlen++;
            end
            if (!trig_out && p_trig) mchk(wlen == T_PULSE, "R6 width", wlen, T_PULSE);
            if (fe_trig) begin
                mchk(cyc - rise_cyc == T_LAT, "R7 latency", cyc - rise_cyc, T_LAT);
                last_fe = cyc;
                fe_n++;
            end
            if (!busy && p_busy && !stop_run)
                mchk(cyc - last_fe == 1, "R10 busy fall", cyc - last_fe, 1);
        end
        p_trig = trig_out;
        p_sclk = dly_sclk;
        p_busy = busy;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy && !wd) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_run(input logic [7:0] d, input int n, input int nexp);
        int t0, f0, l0;
        exp_dly = d;
        wr(2'd0, {8'd0, d});
        wr(2'd1, n[15:0]);
        t0 = trig_n; f0 = fe_n; l0 = load_n;
        wr(2'd2, 16'd1);
        chk(busy == 1'b1, "R10 busy rise", busy, 1);
        wait_idle();
        chk(trig_n - t0 == nexp, "R8 trigger count", trig_n - t0, nexp);
        chk(fe_n - f0 == nexp, "R7 readout count", fe_n - f0, nexp);
        chk(load_n - l0 == 1, "R2 one load per start", load_n - l0, 1);
    endtask

    initial begin
        int t0, f0, l0, s0;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk({trig_out, fe_trig, busy, dly_sdata, dly_sclk, dly_load} == 6'b0, "R1 in reset",
            {trig_out, fe_trig, busy, dly_sdata, dly_sclk, dly_load}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({trig_out, fe_trig, busy, dly_sdata, dly_sclk, dly_load} == 6'b0, "R1 after reset",
            {trig_out, fe_trig, busy, dly_sdata, dly_sclk, dly_load}, 0);

        // R3 R2: every delay code, one event each
        for (int d = 0; d < 256; d++) do_run(d[7:0], 1, 1);

        // R8 R5: each event count, then saturation above MAX_EVT
        for (int n = 1; n <= T_MAXEVT; n++) do_run(8'hA5 ^ n[7:0], n, n);
        do_run(8'h5A, 9, T_MAXEVT);
        do_run(8'h81, 65535, T_MAXEVT);

        // R9: zero event count ignores start
        wr(2'd1, 16'd0);
        t0 = trig_n; l0 = load_n;
        wr(2'd2, 16'd1);
        chk(busy == 1'b0, "R9 zero count start", busy, 0);
        repeat (60) @(negedge clk);
        chk(trig_n == t0 && load_n == l0, "R9 zero count no activity", trig_n - t0, 0);

        // R9: start while busy ignored
        exp_dly = 8'h17;
        wr(2'd0, 16'h0017);
        wr(2'd1, 16'd3);
        t0 = trig_n; l0 = load_n;
        wr(2'd2, 16'd1);
        repeat (50) @(negedge clk);
        wr(2'd2, 16'd1);
        wait_idle();
        chk(trig_n - t0 == 3, "R9 start while busy", trig_n - t0, 3);
        chk(load_n - l0 == 1, "R9 no second load", load_n - l0, 1);

        // R11: writes during a run are deferred
        exp_dly = 8'h3C;
        wr(2'd0, 16'h003C);
        wr(2'd1, 16'd4);
        t0 = trig_n;
        wr(2'd2, 16'd1);
        repeat (45) @(negedge clk);
        s0 = sclk_n; l0 = load_n;
        wr(2'd0, 16'h00C3);
        wr(2'd1, 16'd2);
        wait_idle();
        chk(sclk_n == s0 && load_n == l0, "R11 serial lines quiet", sclk_n - s0, 0);
        chk(trig_n - t0 == 4, "R11 run unchanged", trig_n - t0, 4);
        exp_dly = 8'hC3;
        t0 = trig_n;
        wr(2'd2, 16'd1);
        wait_idle();
        chk(trig_n - t0 == 2, "R11 new count next run", trig_n - t0, 2);

        // R12: stop mid-run after two triggers
        stop_run = 1'b1;
        exp_dly = 8'h66;
        wr(2'd0, 16'h0066);
        wr(2'd1, 16'd6);
        t0 = trig_n; f0 = fe_n;
        wr(2'd2, 16'd1);
        while (trig_n - t0 < 2 && !wd) @(negedge clk);
        repeat (2) @(negedge clk);
        wr(2'd2, 16'd2);
        wait_idle();
        chk(trig_n - t0 == 2, "R12 no trigger after stop", trig_n - t0, 2);
        chk(fe_n - f0 == 2, "R12 pending readout delivered", fe_n - f0, 2);

        // R12: stop during the serial load
        t0 = trig_n; l0 = load_n;
        wr(2'd2, 16'd1);
        wr(2'd2, 16'd2);
        chk(busy == 1'b1, "R12 load completes first", busy, 1);
        wait_idle();
        chk(trig_n == t0, "R12 stop in load", trig_n - t0, 0);
        chk(load_n - l0 == 1, "R12 strobe still issued", load_n - l0, 1);

        // R12: both command bits count as stop
        t0 = trig_n;
        wr(2'd2, 16'd3);
        chk(busy == 1'b0, "R12 start and stop together", busy, 0);
        repeat (60) @(negedge clk);
        chk(trig_n == t0, "R12 no run from both bits", trig_n - t0, 0);
        stop_run = 1'b0;

        if (wd) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks + m_checks, fails + m_fails);
        $finish;
    end

endmodule